// File: doc/BRIEF.md
# Scrambled Clock Pattern Generator

This block produces a scrambled clock. It is a serial level stream in which every slot lasts exactly one bit-clock period, so level changes can only fall on the evenly spaced bit-clock edges. The level carried in each slot follows a fixed pseudorandom pattern that repeats every 256 slots. The slot timing is never modulated. Only the level is pseudorandom, which spreads the emitted energy over many spectral lines while edge placement stays exact.

The pattern is fully specified below, so a receiver can store it or regenerate it. Slots are taken in pairs. Each pair carries a data bit followed by its complement. The data bits come from a short linear feedback shift register, plus one fixed zero that fills the 128th pair. This construction gives an exact balance of ones and zeros and a level change at least every two slots. A single enable starts and stops the stream. Each new start, and each synchronous reset, begins the pattern again at slot 0. The pattern can be read from a constant table or produced on the fly by a small register, and both options give the same bit stream.

Top module: `scr_clk_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `slot_idx` = 0, `bit_out` = 0 and `frame_start` = 0.
- R2: At the first clock edge where `en` is high after a reset or after a clock edge with `en` low, the block starts. After that edge, `slot_idx` = 0 and `frame_start` = 1.
- R3: While started and `en` stays high, `slot_idx` rises by one per clock. It wraps from 255 to 0.
- R4: `frame_start` is high exactly when the block is started and `slot_idx` is 0. In steady running it therefore pulses for one clock every 256 clocks.
- R5: When started, `bit_out` at slot 2k equals d(k) and at slot 2k+1 equals the inverse of d(k), for k from 0 to 127. d(k) is defined by a 7-bit register that starts at value 1. For k < 127, d(k) is bit 0 of that register after k shifts. Each shift moves the register right by one place, and the new bit 6 is bit 0 XOR bit 1. d(127) is 0.
- R6: Every full period of 256 slots carries exactly 128 ones.
- R7: No run of equal levels is longer than 2 slots, including the run that crosses from slot 255 into slot 0.
- R8: After a clock edge with `en` low and `rst` low, `bit_out` = 0, `frame_start` = 0 and `slot_idx` keeps its previous value.
- R9: The table option and the on-the-fly register option give identical `bit_out` streams under the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one slot per period |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; a new start restarts at slot 0 |
| bit_out | output | 1 | Scrambled serial level |
| frame_start | output | 1 | One-clock strobe at slot 0 of each period |
| slot_idx | output | IDX_W (8) | Current slot index |

## Verification
A corrupted slot counter shows up on the next clock. It either breaks the +1 step of `slot_idx` or moves the `frame_start` strobe off the 256-clock spacing. A wrong pattern bit, or a register variant that has drifted out of phase, shows up in the slot where it occurs. It appears as a mismatch against the computed pattern, or as a divergence between the two source variants. It also shows up by the end of that period as a wrong count of ones or as a run of three equal levels. A failed restart is seen one clock after `en` returns high, when the index does not read 0.

// File: rtl/scr_pkg.sv
package scr_pkg;

   localparam int MAX_LOG2 = 10;
   localparam int MAX_PERIOD = 1 << MAX_LOG2;

   typedef enum logic {SRC_TABLE = 1'b0, SRC_LFSR = 1'b1} pat_src_e;

   // Second feedback tap of a primitive trinomial x^w + x^t + 1; 0 means unsupported.
   function automatic int fb_tap(input int w);
      case (w)
         3: return 1;
         4: return 1;
         5: return 2;
         6: return 1;
         7: return 1;
         9: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] shift_next(input logic [15:0] s, input int w);
      logic [15:0] n;
      logic fb;
      fb = s[0] ^ s[fb_tap(w)];
      n = s >> 1;
      n[w-1] = fb;
      return n;
   endfunction

   function automatic logic [MAX_PERIOD-1:0] build_pattern(input int log2p);
      logic [MAX_PERIOD-1:0] pat;
      logic [15:0] s;
      logic d;
      int w;
      int pairs;
      pat = '0;
      w = log2p - 1;
      pairs = 1 << w;
      s = 16'd1;
      for (int k = 0; k < pairs; k++) begin
         d = (k == pairs - 1) ? 1'b0 : s[0];
         pat[2*k]   = d;
         pat[2*k+1] = ~d;
         s = shift_next(s, w);
      end
      return pat;
   endfunction

endpackage

// File: rtl/scr_slot_counter.sv
module scr_slot_counter #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic             act_o,
   output logic             restart_o,
   output logic             step_o,
   output logic [IDX_W-1:0] idx_o
);
   logic             act_q;
   logic [IDX_W-1:0] idx_q;

   assign restart_o = en & ~act_q;
   assign step_o    = en & act_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         idx_q <= '0;
      end else if (!en) begin
         act_q <= 1'b0;
      end else if (!act_q) begin
         act_q <= 1'b1;
         idx_q <= '0;
      end else begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign act_o = act_q;
   assign idx_o = idx_q;
endmodule

// File: rtl/scr_pattern_rom.sv
module scr_pattern_rom #(
   parameter int IDX_W = 8
) (
   input  logic [IDX_W-1:0] idx,
   output logic             bit_o
);
   localparam int PERIOD = 1 << IDX_W;
   localparam logic [scr_pkg::MAX_PERIOD-1:0] FULL = scr_pkg::build_pattern(IDX_W);
   localparam logic [PERIOD-1:0] PAT = FULL[PERIOD-1:0];

   assign bit_o = PAT[idx];
endmodule

// File: rtl/scr_pattern_lfsr.sv
module scr_pattern_lfsr #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             step,
   input  logic [IDX_W-1:0] idx,
   output logic             bit_o
);
   localparam int SW = IDX_W - 1;
   localparam logic [SW-1:0] SEED = SW'(1);
   localparam logic [IDX_W-1:0] LAST = '1;

   logic [SW-1:0] s_q;
   logic [15:0]   s_ext;
   logic [15:0]   s_nxt;
   logic          d;

   assign s_ext = 16'(s_q);
   assign s_nxt = scr_pkg::shift_next(s_ext, SW);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         s_q <= SEED;
      end else if (step && idx[0]) begin
         s_q <= (idx == LAST) ? SEED : s_nxt[SW-1:0];
      end
   end

   assign d     = (idx[IDX_W-1:1] == '1) ? 1'b0 : s_q[0];
   assign bit_o = idx[0] ? ~d : d;
endmodule

// File: rtl/scr_clk_gen.sv
module scr_clk_gen #(
   parameter int               IDX_W = 8,
   parameter scr_pkg::pat_src_e SRC  = scr_pkg::SRC_TABLE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic             bit_out,
   output logic             frame_start,
   output logic [IDX_W-1:0] slot_idx
);
   if (IDX_W < 4 || IDX_W > scr_pkg::MAX_LOG2) begin : g_bad_width
      $error("scr_clk_gen: IDX_W out of supported range");
   end
   if (scr_pkg::fb_tap(IDX_W - 1) == 0) begin : g_bad_tap
      $error("scr_clk_gen: no feedback polynomial for this IDX_W");
   end

   logic             act;
   logic             restart;
   logic             step;
   logic [IDX_W-1:0] idx;
   logic             pat_bit;

   scr_slot_counter #(.IDX_W(IDX_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .act_o    (act),
      .restart_o(restart),
      .step_o   (step),
      .idx_o    (idx)
   );

   if (SRC == scr_pkg::SRC_TABLE) begin : g_rom
      scr_pattern_rom #(.IDX_W(IDX_W)) u_src (
         .idx  (idx),
         .bit_o(pat_bit)
      );
      logic unused_ok;
      assign unused_ok = &{1'b0, restart, step};
   end else begin : g_lfsr
      scr_pattern_lfsr #(.IDX_W(IDX_W)) u_src (
         .clk    (clk),
         .rst    (rst),
         .restart(restart),
         .step   (step),
         .idx    (idx),
         .bit_o  (pat_bit)
      );
   end

   assign bit_out     = act & pat_bit;
   assign frame_start = act & (idx == '0);
   assign slot_idx    = idx;
endmodule

// File: rtl/scr_clk_gen_chk.sv
module scr_clk_gen_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             act,
   input logic             bit_out,
   input logic             frame_start,
   input logic [IDX_W-1:0] slot_idx
);
   localparam int HALF = 1 << (IDX_W - 1);
   localparam logic [IDX_W-1:0] LAST = '1;

   logic [IDX_W:0] ones_q;
   logic [2:0]     run_q;
   logic           prev_q;

   always_ff @(posedge clk) begin
      if (rst || !act) begin
         ones_q <= '0;
      end else if (slot_idx == '0) begin
         ones_q <= (IDX_W+1)'(bit_out);
      end else begin
         ones_q <= ones_q + (IDX_W+1)'(bit_out);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !act) begin
         run_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= bit_out;
         if (run_q == 3'd0 || bit_out != prev_q) run_q <= 3'd1;
         else if (run_q != 3'd7) run_q <= run_q + 3'd1;
      end
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk) rst |=> (slot_idx == '0 && !bit_out && !frame_start));

   // R2
   restart_chk: assert property (@(posedge clk) disable iff (rst) (en && !act) |=> (slot_idx == '0 && frame_start));

   // R3
   step_chk: assert property (@(posedge clk) disable iff (rst)
      (en && act) |=> (slot_idx == IDX_W'($past(slot_idx) + 1'b1)));

   // R4
   strobe_chk: assert property (@(posedge clk) disable iff (rst) frame_start |-> (act && slot_idx == '0));

   // R6
   balance_chk: assert property (@(posedge clk) disable iff (rst)
      (act && slot_idx == LAST) |-> (ones_q + (IDX_W+1)'(bit_out) == (IDX_W+1)'(HALF)));

   // R7
   run_len_chk: assert property (@(posedge clk) disable iff (rst) run_q <= 3'd2);

   // R8
   idle_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!bit_out && !frame_start && $stable(slot_idx)));
endmodule

bind scr_clk_gen scr_clk_gen_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .en         (en),
   .act        (act),
   .bit_out    (bit_out),
   .frame_start(frame_start),
   .slot_idx   (slot_idx)
);

// File: tb/scr_clk_gen_bench.sv
module scr_clk_gen_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       bit_a, fs_a, bit_b, fs_b;
   logic [7:0] idx_a, idx_b;

   scr_clk_gen #(.IDX_W(8), .SRC(scr_pkg::SRC_TABLE)) u_scr_clk_gen (
      .clk(clk), .rst(rst), .en(en), .bit_out(bit_a), .frame_start(fs_a), .slot_idx(idx_a));

   scr_clk_gen #(.IDX_W(8), .SRC(scr_pkg::SRC_LFSR)) u_scr_clk_gen_lfsr (
      .clk(clk), .rst(rst), .en(en), .bit_out(bit_b), .frame_start(fs_b), .slot_idx(idx_b));

   int  n_chk = 0;
   int  n_bad = 0;
   int  cyc   = 0;
   logic exp_pat [256];

   int  e_idx;
   int  ones;
   int  run_len;
   logic prev_lvl;
   int  last_fs;
   bit  full;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
      end
   endtask

   task automatic build_expected();
      logic [6:0] r;
      logic d;
      r = 7'd1;
      for (int k = 0; k < 128; k++) begin
         d = (k == 127) ? 1'b0 : r[0];
         exp_pat[2*k]   = d;
         exp_pat[2*k+1] = ~d;
         r = {r[0] ^ r[1], r[6:1]};
      end
   endtask

   task automatic new_run();
      e_idx = 0; ones = 0; run_len = 0; prev_lvl = 1'b0; last_fs = -1; full = 1'b0;
   endtask

   // Check the current slot, then move to the next negative edge.
   task automatic slot_step();
      chk(idx_a == e_idx[7:0], "R3 slot_idx", idx_a, e_idx);
      chk(bit_a == exp_pat[e_idx], "R5 bit_out", bit_a, exp_pat[e_idx]);
      chk(bit_b == bit_a, "R9 variant match", bit_b, bit_a);
      chk(fs_a == (e_idx == 0), "R4 frame_start", fs_a, e_idx == 0);
      if (e_idx == 0) begin
         if (last_fs >= 0) chk(cyc - last_fs == 256, "R4 strobe spacing", cyc - last_fs, 256);
         last_fs = cyc; ones = 0; full = 1'b1;
      end
      ones += bit_a;
      if (run_len == 0 || bit_a != prev_lvl) run_len = 1; else run_len++;
      prev_lvl = bit_a;
      chk(run_len <= 2, "R7 run length", run_len, 2);
      if (e_idx == 255 && full) chk(ones == 128, "R6 ones per period", ones, 128);
      @(negedge clk);
      e_idx = (e_idx + 1) % 256;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      build_expected();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(idx_a == 0, "R1 idx", idx_a, 0);
      chk(bit_a == 0 && bit_b == 0, "R1 bit_out", bit_a, 0);
      chk(fs_a == 0, "R1 frame_start", fs_a, 0);

      rst = 1'b0; en = 1'b1;
      @(negedge clk);
      // R2 start
      chk(idx_a == 0 && fs_a == 1, "R2 start", {idx_a, fs_a}, 1);
      new_run();
      for (int i = 0; i < 768; i++) slot_step();
      while (e_idx != 100) slot_step();

      en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         // R8 hold while disabled
         chk(bit_a == 0 && bit_b == 0, "R8 bit low", bit_a, 0);
         chk(fs_a == 0, "R8 strobe low", fs_a, 0);
         chk(idx_a == 100, "R8 idx frozen", idx_a, 100);
      end

      en = 1'b1;
      @(negedge clk);
      chk(idx_a == 0 && fs_a == 1 && bit_a == exp_pat[0], "R2 restart", idx_a, 0);
      new_run();
      for (int i = 0; i < 40; i++) slot_step();

      rst = 1'b1;
      @(negedge clk);
      chk(idx_a == 0 && bit_a == 0 && fs_a == 0, "R1 mid-run reset", idx_a, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(idx_a == 0 && fs_a == 1, "R2 start after reset", idx_a, 0);
      new_run();
      for (int i = 0; i < 300; i++) slot_step();

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule